// File: doc/BRIEF.md
# Accumulator Processor with Register-Transfer Microsteps

This block is a small processor core with one accumulator. Its control unit carries out every instruction as a fixed, ordered series of single register transfers. The registers are a program counter, the accumulator, an instruction register, a memory address register and a memory buffer register. All traffic to the external synchronous single-port memory passes through the two memory-facing registers. The address register drives the address pins. The buffer register receives read data and drives write data.

An instruction is one 16-bit word. Bits 15:12 hold the opcode and bits 11:0 hold a direct operand address. Opcode 1 loads the accumulator from memory, 2 stores the accumulator to memory and 3 adds a memory word to the accumulator. Opcode F halts the core. Every other opcode does nothing beyond its fetch.

Memory reads have one clock of latency, so each step that captures read data waits one clock after the address is presented. The accumulator, the program counter, a carry flag and a halt flag are brought out for observation.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is high, and on the first clock after it falls, acc_out, pc_out and carry_out are zero and halted and mem_we are low.
- R2: Fetching an instruction takes 5 clocks: address setup, a read wait, capture into the buffer register, PC increment, and transfer to the instruction register. pc_out advances by exactly 1 for each instruction fetched and never changes in any other way.
- R3: LOAD (opcode 1) sets the accumulator to the memory word at bits 11:0 of the instruction and leaves carry_out unchanged.
- R4: ADD (opcode 3) sets the accumulator to (accumulator + memory word) modulo 2^16, and carry_out to the carry out of bit 15.
- R5: STORE (opcode 2) raises mem_we for exactly one clock, with mem_addr equal to the operand address and mem_wdata equal to the accumulator. The accumulator is left unchanged.
- R6: HALT (opcode F) raises halted after its fetch. From then until reset, halted stays high, pc_out and acc_out hold, and mem_we stays low; the word after the HALT is never executed.
- R7: Any opcode other than 1, 2, 3 and F changes neither the accumulator, the carry nor memory, and the next instruction is fetched right after it.
- R8: Counted in clocks including the fetch, LOAD and ADD take 9, STORE takes 8 and a no-operation takes 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_we | output | 1 | Memory write enable, one clock per store |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data, valid one clock after the address |
| acc_out | output | 16 | Accumulator value |
| pc_out | output | 12 | Program counter value |
| carry_out | output | 1 | Carry flag from the last ADD |
| halted | output | 1 | High once a HALT has been fetched |

## Verification
The bench looks for a missing read wait state. A core without it would load the word at the previous address, so LOAD results and fetched instructions would come out wrong. It adds 0xFFF0 and 0x0020 to get a wrapped sum with carry set, then runs a LOAD to show the carry survives. A design that clears or recomputes carry on LOAD fails that check. It also places a STORE right after a HALT and runs no-operation opcodes whose address fields point at live data. These catch a core that runs past a halt or treats an unknown opcode as a load. Clock counts to halt are compared for every program, which exposes any extra or missing step.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPW-1:0] OP_STORE = 4'h2;
  localparam logic [OPW-1:0] OP_ADD   = 4'h3;
  localparam logic [OPW-1:0] OP_HALT  = 4'hF;

  // Microstep register: fetch F1..F4, execute E1..E3, plus read waits.
  typedef enum logic [3:0] {
    ST_F1, ST_F2W, ST_F2, ST_F3, ST_F4,
    ST_E1, ST_E2W, ST_E2, ST_E3, ST_HALT
  } step_e;

  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_STORE, K_ADD, K_HALT
  } kind_e;

  function automatic kind_e decode_op(input logic [OPW-1:0] op);
    case (op)
      OP_LOAD:  return K_LOAD;
      OP_STORE: return K_STORE;
      OP_ADD:   return K_ADD;
      OP_HALT:  return K_HALT;
      default:  return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b};
    sum  = full[DW-1:0];
    cout = full[DW];
  end
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] mbr_op,
  input  logic [OPW-1:0] ir_op,
  output step_e          step
);
  step_e nxt;
  kind_e fetched_kind;
  kind_e held_kind;

  always_comb begin
    // In F4 the word is still in the buffer register, so decode it there.
    fetched_kind = decode_op(mbr_op);
    held_kind    = decode_op(ir_op);
    case (step)
      ST_F1:  nxt = ST_F2W;
      ST_F2W: nxt = ST_F2;
      ST_F2:  nxt = ST_F3;
      ST_F3:  nxt = ST_F4;
      ST_F4: begin
        case (fetched_kind)
          K_NONE:  nxt = ST_F1;
          K_HALT:  nxt = ST_HALT;
          default: nxt = ST_E1;
        endcase
      end
      ST_E1:   nxt = (held_kind == K_STORE) ? ST_E2 : ST_E2W;
      ST_E2W:  nxt = ST_E2;
      ST_E2:   nxt = ST_E3;
      ST_E3:   nxt = ST_F1;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step <= ST_F1;
    else     step <= nxt;
  end
endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath
  import acc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  step_e         step,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] alu_sum,
  input  logic          alu_cout,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ac,
  output logic [DW-1:0] ir,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic          cy,
  output logic          we
);
  kind_e kind;

  always_comb kind = decode_op(ir[DW-1 -: OPW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ac  <= '0;
      ir  <= '0;
      mar <= '0;
      mbr <= '0;
      cy  <= 1'b0;
      we  <= 1'b0;
    end else begin
      we <= 1'b0;
      case (step)
        ST_F1: mar <= pc;
        ST_F2: mbr <= mem_rdata;
        ST_F3: pc  <= pc + AW'(1);
        ST_F4: ir  <= mbr;
        ST_E1: mar <= ir[AW-1:0];
        ST_E2: begin
          if (kind == K_STORE) begin
            mbr <= ac;
            we  <= 1'b1;  // write happens during E3
          end else begin
            mbr <= mem_rdata;
          end
        end
        ST_E3: begin
          if (kind == K_LOAD) begin
            ac <= mbr;
          end else if (kind == K_ADD) begin
            ac <= alu_sum;
            cy <= alu_cout;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_out,
  output logic [AW-1:0] pc_out,
  output logic          carry_out,
  output logic          halted
);
  step_e         step;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] ac, ir, mbr, sum;
  logic          cy, we, cout;

  acc_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .mbr_op (mbr[DW-1 -: OPW]),
    .ir_op  (ir[DW-1 -: OPW]),
    .step   (step)
  );

  acc_seq_alu #(.DW(DW)) u_alu (
    .a    (ac),
    .b    (mbr),
    .sum  (sum),
    .cout (cout)
  );

  acc_seq_dpath #(.DW(DW), .AW(AW)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .mem_rdata (mem_rdata),
    .alu_sum   (sum),
    .alu_cout  (cout),
    .pc        (pc),
    .ac        (ac),
    .ir        (ir),
    .mar       (mar),
    .mbr       (mbr),
    .cy        (cy),
    .we        (we)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = we;
  assign acc_out   = ac;
  assign pc_out    = pc;
  assign carry_out = cy;
  assign halted    = (step == ST_HALT);
endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] acc_out,
  input logic [AW-1:0] pc_out,
  input logic          carry_out,
  input logic          halted
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pc_out == '0 && acc_out == '0 && !carry_out && !halted && !mem_we));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> pc_out == AW'($past(pc_out) + 1'b1));

  p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_we_data_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc_out && $stable(mem_addr)));

  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(pc_out) && $stable(acc_out) && !mem_we));
endmodule

bind acc_seq_core acc_seq_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .acc_out   (acc_out),
  .pc_out    (pc_out),
  .carry_out (carry_out),
  .halted    (halted)
);

// File: tb/acc_seq_core_bench.sv
`timescale 1ns/1ps
module acc_seq_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] acc_out;
  logic [11:0] pc_out;
  logic        carry_out;
  logic        halted;

  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] mem [0:255];
  int          we_cnt;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  acc_seq_core u_acc_seq_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_out(acc_out),
    .pc_out(pc_out), .carry_out(carry_out), .halted(halted)
  );

  // Synchronous memory, one clock read latency, preload port for the bench.
  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  always @(posedge clk) begin
    if (rst) we_cnt <= 0;
    else if (mem_we) we_cnt <= we_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic clear_mem();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) poke(8'(i), 16'h0000);
  endtask

  task automatic run_prog(output int n);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 2000) begin
      @(posedge clk);
      n = n + 1;
      @(negedge clk);
    end
  endtask

  task automatic t_load();
    int n;
    clear_mem();
    poke(8'h00, 16'h1020); poke(8'h01, 16'hF000); poke(8'h20, 16'h1234);
    run_prog(n);
    chk("R3", "load acc", {16'h0, acc_out}, 32'h1234);
    chk("R3", "load carry", {31'h0, carry_out}, 32'h0);
    chk("R2", "pc after 2 fetches", {20'h0, pc_out}, 32'h2);
    chk("R8", "cycles load+halt", n, 14);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "acc in reset", {16'h0, acc_out}, 32'h0);
    chk("R1", "pc in reset", {20'h0, pc_out}, 32'h0);
    chk("R1", "halted in reset", {31'h0, halted}, 32'h0);
    chk("R1", "we in reset", {31'h0, mem_we}, 32'h0);
  endtask

  task automatic t_add_carry();
    int n;
    clear_mem();
    poke(8'h00, 16'h1020); poke(8'h01, 16'h3021); poke(8'h02, 16'h1023);
    poke(8'h03, 16'hF000);
    poke(8'h20, 16'hFFF0); poke(8'h21, 16'h0020); poke(8'h23, 16'h5555);
    run_prog(n);
    chk("R4", "carry after wrap, kept by LOAD (R3)", {31'h0, carry_out}, 32'h1);
    chk("R3", "acc after load", {16'h0, acc_out}, 32'h5555);
    clear_mem();
    poke(8'h00, 16'h1020); poke(8'h01, 16'h3021); poke(8'h02, 16'h3022);
    poke(8'h03, 16'hF000);
    poke(8'h20, 16'hFFF0); poke(8'h21, 16'h0020); poke(8'h22, 16'h0001);
    run_prog(n);
    chk("R4", "wrapped sum", {16'h0, acc_out}, 32'h0011);
    chk("R4", "carry cleared by add", {31'h0, carry_out}, 32'h0);
    chk("R2", "pc after 4 fetches", {20'h0, pc_out}, 32'h4);
    chk("R8", "cycles load+add+add+halt", n, 32);
  endtask

  task automatic t_store();
    int n;
    clear_mem();
    poke(8'h00, 16'h1020); poke(8'h01, 16'h2030); poke(8'h02, 16'h2031);
    poke(8'h03, 16'hF000);
    poke(8'h20, 16'hBEEF); poke(8'h32, 16'h7777);
    run_prog(n);
    chk("R5", "mem[30]", {16'h0, mem[8'h30]}, 32'hBEEF);
    chk("R5", "mem[31]", {16'h0, mem[8'h31]}, 32'hBEEF);
    chk("R5", "mem[32] untouched", {16'h0, mem[8'h32]}, 32'h7777);
    chk("R5", "acc unchanged", {16'h0, acc_out}, 32'hBEEF);
    chk("R5", "write pulses", we_cnt, 2);
    chk("R8", "cycles load+store+store+halt", n, 30);
  endtask

  task automatic t_nop();
    int n;
    clear_mem();
    poke(8'h00, 16'h1020); poke(8'h01, 16'h0021); poke(8'h02, 16'h7021);
    poke(8'h03, 16'h4021); poke(8'h04, 16'hF000);
    poke(8'h20, 16'h00AA); poke(8'h21, 16'h1111);
    run_prog(n);
    chk("R7", "acc after nops", {16'h0, acc_out}, 32'h00AA);
    chk("R7", "carry after nops", {31'h0, carry_out}, 32'h0);
    chk("R7", "no writes", we_cnt, 0);
    chk("R7", "mem[21] kept", {16'h0, mem[8'h21]}, 32'h1111);
    chk("R2", "pc after 5 fetches", {20'h0, pc_out}, 32'h5);
    chk("R8", "cycles load+3 nop+halt", n, 29);
  endtask

  task automatic t_halt();
    int n;
    clear_mem();
    poke(8'h00, 16'h1020); poke(8'h01, 16'hF000); poke(8'h02, 16'h2030);
    poke(8'h20, 16'h4321); poke(8'h30, 16'h9999);
    run_prog(n);
    repeat (40) @(negedge clk);
    chk("R6", "halted held", {31'h0, halted}, 32'h1);
    chk("R6", "pc frozen", {20'h0, pc_out}, 32'h2);
    chk("R6", "acc frozen", {16'h0, acc_out}, 32'h4321);
    chk("R6", "store after halt not run", {16'h0, mem[8'h30]}, 32'h9999);
    chk("R6", "no writes", we_cnt, 0);
  endtask

  initial begin
    t_load();
    t_reset();
    t_add_carry();
    t_store();
    t_nop();
    t_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule